// File: doc/BRIEF.md
# Receive Buffer Wrap and Trigger Monitor

This block watches a circular receive buffer that accepts one received word per strobe. It moves its own write pointer through the buffer, and it keeps a two-level history of buffer overruns that the host can read and clear. The first time the pointer wraps, the block records a single wrap. Any further wrap that happens before the host has cleared that record marks the buffer contents as lost.

The same strobe also drives a free-running 16-bit word counter, which feeds two triggers. The first is a one-shot match that fires when the counter reaches a programmed target. The second is a periodic trigger that fires on every Nth word. Each trigger sets a sticky flag. A flag drives the interrupt line only when its enable bit is set.

The host reaches all of this through a small register bus with an 8-bit address, separate write and read strobes, and 16-bit data. Read data is combinational while the read strobe is high.

Top module: `rxm_monitor`

## Requirements
- R1: After reset, every readable register reads 0, the write pointer is 0 and irq is low.
- R2: Each cycle with word_stb high advances wr_ptr by one. From DEPTH-1 it returns to 0. wr_ptr holds when word_stb is low.
- R3: Register 0x2A holds the wrap history. When the pointer wraps while bit 14 is clear, bit 14 sets. When it wraps while bit 14 is set, bit 15 sets. Bits 13:0 always read 0.
- R4: A write to 0x2A clears bit 14 where wdata[14]=1 and bit 15 where wdata[15]=1. In a cycle that also wraps the pointer, the write is ignored and only the wrap update is applied.
- R5: Register 0x34 reads the word counter. The counter adds one per strobe, wraps from 65535 to 0, and any write to 0x34 sets it to 0. That write takes priority over a strobe in the same cycle.
- R6: Register 0x2C (write-only, reads 0) holds a count target. Flag bit 0 of 0x32 sets on the strobe that makes the counter equal the target. A target of 0 never fires.
- R7: Register 0x2E (write-only, reads 0) holds N. Flag bit 1 of 0x32 sets on every Nth strobe counted from the last write to 0x2E. Writing 0x2E restarts that progress, and N=0 disables the trigger.
- R8: Writing 1 to a bit of 0x32 clears that flag. If the flag's trigger fires in the same cycle, the flag stays set.
- R9: Register 0x30 bits 1:0 enable the count flag and the interval flag respectively. irq is high exactly when some set flag has its enable bit set.
- R10: host_rdata is 0 while host_rd is low and for any address not listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | One received word accepted this cycle |
| host_addr | input | 8 | Register byte offset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational |
| wr_ptr | output | AW | Current buffer write address |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the edge cases that are easy to get wrong:
- A host clear of the wrap history in the same cycle as a wrap. If the clear were allowed to win, the single-wrap bit would be lost and the data-lost bit would never set.
- A flag clear in the same cycle as a new trigger. A design that applies the clear last would drop that trigger.
- The word counter rolling from 65535 to 0, and a counter reset that lands on a strobe. A design that gets either wrong would read back a stale or off-by-one count.
- A rewrite of N partway through an interval, and N or the target set to 0. A design that keeps old progress or treats 0 as a real value would fire early or fire at all.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_WRAP = 8'h2A;
  localparam logic [ADDR_W-1:0] A_CTGT = 8'h2C;
  localparam logic [ADDR_W-1:0] A_IVL  = 8'h2E;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h30;
  localparam logic [ADDR_W-1:0] A_FLAG = 8'h32;
  localparam logic [ADDR_W-1:0] A_CNT  = 8'h34;

  localparam int BIT_ONE   = 14;
  localparam int BIT_MULTI = 15;

  typedef struct packed {
    logic ivl;
    logic cnt;
  } trig_t;
endpackage

// File: rtl/rxm_wrap_track.sv
module rxm_wrap_track #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          clr_req,
  input  logic [1:0]    clr_mask,
  output logic [AW-1:0] ptr_o,
  output logic          one_o,
  output logic          multi_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          one_q, one_d, multi_q, multi_d;
  logic          wrap_ev;

  assign wrap_ev = stb && (ptr_q == LAST);

  always_comb begin
    ptr_d   = ptr_q;
    one_d   = one_q;
    multi_d = multi_q;
    if (stb) begin
      ptr_d = wrap_ev ? '0 : ptr_q + 1'b1;
    end
    if (wrap_ev) begin
      if (one_q) multi_d = 1'b1;
      else       one_d   = 1'b1;
    end else if (clr_req) begin
      if (clr_mask[0]) one_d   = 1'b0;
      if (clr_mask[1]) multi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      one_q   <= 1'b0;
      multi_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      one_q   <= one_d;
      multi_q <= multi_d;
    end
  end

  assign ptr_o   = ptr_q;
  assign one_o   = one_q;
  assign multi_o = multi_q;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(ptr_q)); // R2
  AST_FIRST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && !one_q) |=> one_q); // R3
  AST_SECOND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && one_q) |=> (one_q && multi_q)); // R4
  AST_MULTI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_q && !clr_req) |=> multi_q); // R3
endmodule

// File: rtl/rxm_trig.sv
module rxm_trig #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          cnt_clr,
  input  logic          tgt_we,
  input  logic          ivl_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_hit,
  output logic          ivl_hit
);
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CW-1:0] tgt_q, tgt_d;
  logic [CW-1:0] ivn_q, ivn_d, ivc_q, ivc_d, ivc_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign ivc_inc = ivc_q + 1'b1;

  always_comb begin
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    ivn_d   = ivn_q;
    ivc_d   = ivc_q;
    cnt_hit = 1'b0;
    ivl_hit = 1'b0;
    if (cnt_clr) begin
      cnt_d = '0;
    end else if (stb) begin
      cnt_d   = cnt_inc;
      cnt_hit = (tgt_q != '0) && (cnt_inc == tgt_q);
    end
    if (tgt_we) tgt_d = wdata;
    if (ivl_we) begin
      ivn_d = wdata;
      ivc_d = '0;
    end else if (stb && (ivn_q != '0)) begin
      if (ivc_inc == ivn_q) begin
        ivc_d   = '0;
        ivl_hit = 1'b1;
      end else begin
        ivc_d = ivc_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgt_q <= '0;
      ivn_q <= '0;
      ivc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
      ivn_q <= ivn_d;
      ivc_q <= ivc_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !cnt_clr) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0)); // R5
  AST_IVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ivn_q != '0) |-> (ivc_q < ivn_q)); // R7
  AST_HIT_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hit || ivl_hit) |-> stb); // R6
endmodule

// File: rtl/rxm_monitor.sv
module rxm_monitor
  import rxm_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [AW-1:0]     wr_ptr,
  output logic              irq
);
  logic          we_wrap, we_ctgt, we_ivl, we_ien, we_flag, we_cnt;
  logic          w_one, w_multi;
  logic          hit_cnt, hit_ivl;
  logic [DATA_W-1:0] cnt_val;
  trig_t         flg_q, flg_d, set_v, clr_v, en_q, en_d;

  assign we_wrap = host_wr && (host_addr == A_WRAP);
  assign we_ctgt = host_wr && (host_addr == A_CTGT);
  assign we_ivl  = host_wr && (host_addr == A_IVL);
  assign we_ien  = host_wr && (host_addr == A_IEN);
  assign we_flag = host_wr && (host_addr == A_FLAG);
  assign we_cnt  = host_wr && (host_addr == A_CNT);

  rxm_wrap_track #(.DEPTH(DEPTH)) u_wrap (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (word_stb),
    .clr_req  (we_wrap),
    .clr_mask ({host_wdata[BIT_MULTI], host_wdata[BIT_ONE]}),
    .ptr_o    (wr_ptr),
    .one_o    (w_one),
    .multi_o  (w_multi)
  );

  rxm_trig #(.CW(DATA_W)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (word_stb),
    .cnt_clr (we_cnt),
    .tgt_we  (we_ctgt),
    .ivl_we  (we_ivl),
    .wdata   (host_wdata),
    .cnt_o   (cnt_val),
    .cnt_hit (hit_cnt),
    .ivl_hit (hit_ivl)
  );

  always_comb begin
    set_v.cnt = hit_cnt;
    set_v.ivl = hit_ivl;
    clr_v     = we_flag ? trig_t'(host_wdata[1:0]) : '0;
    flg_d     = (flg_q & ~clr_v) | set_v;
    en_d      = we_ien ? trig_t'(host_wdata[1:0]) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      en_q  <= '0;
    end else begin
      flg_q <= flg_d;
      en_q  <= en_d;
    end
  end

  assign irq = |(flg_q & en_q);

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      unique case (host_addr)
        A_WRAP: begin
          host_rdata[BIT_ONE]   = w_one;
          host_rdata[BIT_MULTI] = w_multi;
        end
        A_IEN:   host_rdata[1:0] = en_q;
        A_FLAG:  host_rdata[1:0] = flg_q;
        A_CNT:   host_rdata      = cnt_val;
        default: host_rdata      = '0;
      endcase
    end
  end

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt |=> flg_q.cnt); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q.ivl && !we_flag) |=> flg_q.ivl); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0)); // R9
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |-> (host_rdata == '0)); // R10
endmodule

// File: tb/rxm_monitor_tb.sv
`timescale 1ns/1ps
module rxm_monitor_tb;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          word_stb, host_wr, host_rd;
  logic [7:0]    host_addr;
  logic [15:0]   host_wdata, host_rdata;
  logic [AW-1:0] wr_ptr;
  logic          irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  rxm_monitor #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .wr_ptr(wr_ptr), .irq(irq)
  );

  // behavioural reference model
  int       m_ptr, m_cnt, m_tgt, m_ivn, m_ivc;
  bit       m_one, m_multi;
  bit [1:0] m_flg, m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_cnt = 0; m_tgt = 0; m_ivn = 0; m_ivc = 0;
      m_one = 0; m_multi = 0; m_flg = 0; m_en = 0;
    end else begin
      bit wrap, clr_cnt;
      bit [1:0] setm, clrm;
      wrap = word_stb && (m_ptr == DEPTH - 1);
      clr_cnt = host_wr && host_addr == 8'h34;
      setm = 0;
      clrm = (host_wr && host_addr == 8'h32) ? host_wdata[1:0] : 2'b00;
      if (wrap) begin
        if (m_one) m_multi = 1; else m_one = 1;
      end else if (host_wr && host_addr == 8'h2A) begin
        if (host_wdata[14]) m_one = 0;
        if (host_wdata[15]) m_multi = 0;
      end
      if (word_stb) m_ptr = (m_ptr + 1) % DEPTH;
      if (clr_cnt) m_cnt = 0;
      else if (word_stb) begin
        m_cnt = (m_cnt + 1) % 65536;
        if (m_tgt != 0 && m_cnt == m_tgt) setm[0] = 1;
      end
      if (host_wr && host_addr == 8'h2E) begin
        m_ivn = host_wdata; m_ivc = 0;
      end else if (word_stb && m_ivn != 0) begin
        m_ivc++;
        if (m_ivc == m_ivn) begin m_ivc = 0; setm[1] = 1; end
      end
      if (host_wr && host_addr == 8'h2C) m_tgt = host_wdata;
      m_flg = (m_flg & ~clrm) | setm;
      if (host_wr && host_addr == 8'h30) m_en = host_wdata[1:0];
    end
  end

  function automatic logic [15:0] model_read(input logic [7:0] a);
    case (a)
      8'h2A:   return {m_multi, m_one, 14'b0};
      8'h30:   return {14'b0, m_en};
      8'h32:   return {14'b0, m_flg};
      8'h34:   return m_cnt[15:0];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of register-driven outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 wr_ptr", 16'(wr_ptr), m_ptr[15:0]);
      chk("R9 irq", {15'b0, irq}, {15'b0, |(m_flg & m_en)});
    end
  end

  task automatic step(input bit s, input bit w, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    word_stb = s; host_wr = w; host_rd = 0; host_addr = a; host_wdata = d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    step(0, 1, a, d);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 8'h00, 16'h0);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    @(negedge clk);
    word_stb = 0; host_wr = 0; host_rd = 1; host_addr = a; host_wdata = 0;
    #1;
    chk(tag, host_rdata, model_read(a));
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [15:0] exp);
    rd_chk(tag, a);
    chk(tag, host_rdata, exp);
  endtask

  initial begin
    #1_900_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; word_stb = 0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_lit("R1 wrap", 8'h2A, 16'h0);
    rd_lit("R1 ien", 8'h30, 16'h0);
    rd_lit("R1 flags", 8'h32, 16'h0);
    rd_lit("R1 count", 8'h34, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R6 count target match, R9 enable
    wr(8'h30, 16'h3);
    wr(8'h2C, 16'd5);
    strobes(4);
    rd_lit("R6 before target", 8'h32, 16'h0);
    strobes(1);
    rd_lit("R6 at target", 8'h32, 16'h1);
    rd_lit("R5 count", 8'h34, 16'd5);
    rd_lit("R6 write-only", 8'h2C, 16'h0);
    chk("R9 irq on", {15'b0, irq}, 16'h1);

    // R8 clear
    wr(8'h32, 16'h1);
    rd_lit("R8 cleared", 8'h32, 16'h0);
    chk("R9 irq off", {15'b0, irq}, 16'h0);

    // R7 interval
    wr(8'h2E, 16'd3);
    strobes(2);
    rd_lit("R7 before N", 8'h32, 16'h0);
    strobes(1);
    rd_lit("R7 at N", 8'h32, 16'h2);
    wr(8'h32, 16'h2);
    strobes(2);
    wr(8'h2E, 16'd3);
    strobes(2);
    rd_lit("R7 restart", 8'h32, 16'h0);
    strobes(1);
    rd_lit("R7 after restart", 8'h32, 16'h2);
    rd_lit("R7 write-only", 8'h2E, 16'h0);
    wr(8'h2E, 16'd0);
    wr(8'h32, 16'h2);
    strobes(10);
    rd_lit("R7 disabled", 8'h32, 16'h0);

    // R8 set wins over clear
    wr(8'h2E, 16'd2);
    strobes(1);
    step(1, 1, 8'h32, 16'h2);
    rd_lit("R8 set wins", 8'h32, 16'h2);
    wr(8'h2E, 16'd0);
    wr(8'h32, 16'h3);
    wr(8'h30, 16'h0);
    rd_lit("R9 ien", 8'h30, 16'h0);

    // R3/R4 wrap history
    strobes(DEPTH - m_ptr);
    rd_lit("R3 single", 8'h2A, 16'h4000);
    wr(8'h2A, 16'h4000);
    rd_lit("R4 clear", 8'h2A, 16'h0);
    strobes(DEPTH);
    rd_lit("R3 single again", 8'h2A, 16'h4000);
    strobes(DEPTH);
    rd_lit("R3 multi", 8'h2A, 16'hC000);
    wr(8'h2A, 16'hFFFF);
    rd_lit("R4 clear both", 8'h2A, 16'h0);
    strobes(DEPTH);
    strobes(DEPTH - 1);
    step(1, 1, 8'h2A, 16'hC000);
    rd_lit("R4 wrap beats clear", 8'h2A, 16'hC000);
    wr(8'h2A, 16'hC000);

    // R5 counter reset, priority, rollover
    step(1, 1, 8'h34, 16'h0);
    rd_lit("R5 reset beats strobe", 8'h34, 16'h0);
    wr(8'h2C, 16'd2);
    wr(8'h32, 16'h3);
    wr(8'h30, 16'h1);
    strobes(65535);
    wr(8'h32, 16'h3);
    rd_lit("R5 max", 8'h34, 16'hFFFF);
    strobes(1);
    rd_lit("R5 rollover", 8'h34, 16'h0000);
    strobes(2);
    rd_lit("R6 after rollover", 8'h32, 16'h1);

    // R6 target zero
    wr(8'h2C, 16'd0);
    wr(8'h32, 16'h3);
    step(0, 1, 8'h34, 16'h0);
    strobes(3);
    rd_lit("R6 target zero", 8'h32, 16'h0);

    // R10 idle and unmapped reads
    rd_lit("R10 unmapped", 8'h10, 16'h0);
    step(0, 0, 8'h34, 16'h0);
    #1;
    chk("R10 rd low", host_rdata, 16'h0);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule